// File: doc/BRIEF.md
# Block-Addressable Read Pointer Controller

This block owns the read address pointer of a sequential field memory. The pointer moves through the array one word per serial read clock edge while read enable is high. A reset-read strobe returns the pointer to word zero. The same strobe can also open a short handshake that moves the pointer to the first word of any block in the array.

After an accepted rising edge of the strobe, the controller checks the output-enable and read-enable pins on four clock edges in a row. If the pins carry the unlock pattern, the output-enable pin becomes a serial input. A block number then arrives on it, most significant bit first. The pointer loads the block's base word. A fixed latency hold-off follows before sequential reading may resume. While the handshake runs, the data outputs are kept disabled. A busy flag covers the whole handshake. A sticky error flag reports a bad block number or a strobe edge that arrived too early.

The default configuration has 6144 blocks of 40 words, a 13-bit block number and a 55-edge hold-off. All four values are parameters.

Top module: `rdptr_ctrl`

## Requirements
- R1: While `rst_n` is low and at its release, `ptr` is 0 and `out_en`, `busy` and `err` are 0.
- R2: Outside a handshake, each clock edge with `re` high advances `ptr` by one. The word after DEPTH-1 (DEPTH = BLOCKS*WPB) is 0. An edge with `re` low leaves `ptr` unchanged.
- R3: An accepted rising edge of `rd_rst` (the strobe sampled high after being sampled low) sets `ptr` to 0 on that same edge and clears `err`.
- R4: The handshake edges are numbered from 1, the accepting edge. Edges 1 and 2 must see `oe`=0 and `re`=1. Edges 3 and 4 must see `oe`=1 and `re`=0. On the first edge that breaks this pattern, `busy` falls and the block returns to plain behaviour: `ptr` follows R2 (edge 1 still zeroes it) and `out_en` follows R11.
- R5: From edge 4 onward, the next BLK_BITS edges take `oe` as the block number, most significant bit first. `out_en` stays 0 from edge 4 until the hold-off ends, whatever `oe` does.
- R6: If the received number is below BLOCKS, `ptr` becomes number*WPB on the last address edge. `busy` stays high.
- R7: If the received number is BLOCKS or more, `err` is set, `ptr` keeps its value and `busy` falls on the last address edge.
- R8: After a valid load, `busy` stays high and `ptr` holds for LATENCY more edges. `busy` is low after the LATENCY-th edge. The next edge with `re` high advances `ptr`.
- R9: A rising edge of `rd_rst` while `busy` is high sets `err`, drops `busy` and leaves `ptr` unchanged. If it falls on the last address edge, it wins over the load.
- R10: After an accepted strobe, a new rising edge is accepted only after two edges with `rd_rst` low and `re` high. An earlier rise is ignored: no pointer reset, no busy.
- R11: Outside the muted window of R5, `out_en` takes the value of `oe` sampled at each edge.
- R12: `busy` is high from the edge-1 pattern match until the handshake ends by R4, R7, R8 or R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial read clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_rst | input | 1 | Reset-read strobe |
| oe | input | 1 | Output enable, serial block number during a handshake |
| re | input | 1 | Read enable, pointer advance |
| ptr | output | $clog2(BLOCKS*WPB) | Current read word address |
| out_en | output | 1 | Data output drive enable |
| busy | output | 1 | Handshake or hold-off in progress |
| err | output | 1 | Sticky bad-block or early-strobe flag |

## Verification
The block load and a second strobe rise can fall on the same edge: the final address bit arrives while `rd_rst` rises again. The bench provokes this by raising the strobe exactly on the last address edge of a valid block number, and again part-way through the hold-off. It judges the outcome by the pointer keeping its pre-load value (or the loaded base, in the hold-off case), by `err` being set and by `busy` dropping on that same edge. Every block number of a small configuration, valid and invalid, is also swept through a full handshake.

// File: rtl/rdptr_pkg.sv
package rdptr_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_CHK,
    SQ_SHIFT,
    SQ_LAT
  } seq_st_e;

  // Expected pin pattern on handshake edge pos (1-based)
  function automatic logic unlock_ok(int pos, logic oe_v, logic re_v);
    return (pos <= 2) ? (!oe_v && re_v) : (oe_v && !re_v);
  endfunction

  function automatic int unsigned block_base(int unsigned blk, int unsigned wpb);
    return blk * wpb;
  endfunction

  function automatic logic blk_valid(int unsigned blk, int unsigned nblk);
    return blk < nblk;
  endfunction

  function automatic int unsigned next_word(int unsigned p, int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/rdptr_strobe.sv
module rdptr_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_rst,
  input  logic re,
  input  logic busy,
  output logic start,
  output logic abort
);
  logic       rst_q;
  logic [1:0] quiet;
  logic       rise;

  assign rise  = rd_rst & ~rst_q;
  assign start = rise & ~busy & quiet[1];
  assign abort = rise & busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 1'b0;
      quiet <= 2'd2;
    end else begin
      rst_q <= rd_rst;
      if (start)
        quiet <= 2'd0;
      else if (!rd_rst && re && !quiet[1])
        quiet <= quiet + 2'd1;
    end
  end
endmodule

// File: rtl/rdptr_seq.sv
module rdptr_seq
  import rdptr_pkg::*;
#(
  parameter int BLOCKS   = 6144,
  parameter int BLK_BITS = 13,
  parameter int LATENCY  = 55
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                abort,
  input  logic                oe,
  input  logic                re,
  output logic                busy,
  output logic                freeze,
  output logic                mute,
  output logic                load,
  output logic                bad,
  output logic [BLK_BITS-1:0] blk
);
  localparam int CNT_W = $clog2(BLK_BITS + 4);
  localparam int LAT_W = $clog2(LATENCY + 1);

  seq_st_e             st, nxt;
  logic [CNT_W-1:0]    cnt, nxt_cnt;
  logic [LAT_W-1:0]    lat, nxt_lat;
  logic [BLK_BITS-1:0] shreg, nxt_sh, cand;

  assign cand = {shreg[BLK_BITS-2:0], oe};

  always_comb begin
    nxt     = st;
    nxt_cnt = cnt;
    nxt_lat = lat;
    nxt_sh  = shreg;
    load    = 1'b0;
    bad     = 1'b0;
    case (st)
      SQ_IDLE:
        if (start && unlock_ok(1, oe, re)) begin
          nxt     = SQ_CHK;
          nxt_cnt = CNT_W'(1);
        end
      SQ_CHK:
        if (abort) nxt = SQ_IDLE;
        else if (unlock_ok(int'(32'(cnt)) + 1, oe, re)) begin
          if (cnt == CNT_W'(3)) begin
            nxt     = SQ_SHIFT;
            nxt_cnt = '0;
          end else nxt_cnt = cnt + 1'b1;
        end else nxt = SQ_IDLE;
      SQ_SHIFT:
        if (abort) nxt = SQ_IDLE;
        else begin
          nxt_sh = cand;
          if (cnt == CNT_W'(BLK_BITS - 1)) begin
            if (blk_valid(32'(cand), BLOCKS)) begin
              load    = 1'b1;
              nxt     = SQ_LAT;
              nxt_lat = '0;
            end else begin
              bad = 1'b1;
              nxt = SQ_IDLE;
            end
          end else nxt_cnt = cnt + 1'b1;
        end
      SQ_LAT:
        if (abort) nxt = SQ_IDLE;
        else if (lat == LAT_W'(LATENCY - 1)) nxt = SQ_IDLE;
        else nxt_lat = lat + 1'b1;
      default: nxt = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= SQ_IDLE;
      cnt   <= '0;
      lat   <= '0;
      shreg <= '0;
    end else begin
      st    <= nxt;
      cnt   <= nxt_cnt;
      lat   <= nxt_lat;
      shreg <= nxt_sh;
    end
  end

  assign blk    = cand;
  assign busy   = (st != SQ_IDLE);
  assign freeze = (st == SQ_SHIFT) || (st == SQ_LAT);
  assign mute   = (nxt == SQ_SHIFT) || (nxt == SQ_LAT);
endmodule

// File: rtl/rdptr_ptr.sv
module rdptr_ptr
  import rdptr_pkg::*;
#(
  parameter int DEPTH = 245760,
  parameter int PTR_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             freeze,
  input  logic             re,
  output logic [PTR_W-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (start)  ptr <= '0;
    else if (abort)  ptr <= ptr;
    else if (load)   ptr <= load_val;
    else if (freeze) ptr <= ptr;
    else if (re)     ptr <= PTR_W'(next_word(32'(ptr), DEPTH));
  end
endmodule

// File: rtl/rdptr_ctrl.sv
module rdptr_ctrl
  import rdptr_pkg::*;
#(
  parameter int BLOCKS   = 6144,
  parameter int WPB      = 40,
  parameter int BLK_BITS = 13,
  parameter int LATENCY  = 55,
  localparam int DEPTH   = BLOCKS * WPB,
  localparam int PTR_W   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_rst,
  input  logic             oe,
  input  logic             re,
  output logic [PTR_W-1:0] ptr,
  output logic             out_en,
  output logic             busy,
  output logic             err
);
  logic                rd_start, rd_abort;
  logic                seq_freeze, seq_mute, seq_load, seq_bad;
  logic [BLK_BITS-1:0] seq_blk;
  logic [PTR_W-1:0]    seq_base;

  assign seq_base = PTR_W'(block_base(32'(seq_blk), WPB));

  rdptr_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .rd_rst(rd_rst), .re(re), .busy(busy),
    .start(rd_start), .abort(rd_abort)
  );

  rdptr_seq #(.BLOCKS(BLOCKS), .BLK_BITS(BLK_BITS), .LATENCY(LATENCY)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(rd_start), .abort(rd_abort),
    .oe(oe), .re(re), .busy(busy), .freeze(seq_freeze), .mute(seq_mute),
    .load(seq_load), .bad(seq_bad), .blk(seq_blk)
  );

  rdptr_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .start(rd_start), .abort(rd_abort),
    .load(seq_load), .load_val(seq_base), .freeze(seq_freeze), .re(re),
    .ptr(ptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err    <= 1'b0;
      out_en <= 1'b0;
    end else begin
      out_en <= oe & ~seq_mute;
      if (rd_start) err <= 1'b0;
      else if (rd_abort || seq_bad) err <= 1'b1;
    end
  end
endmodule

// File: rtl/rdptr_chk.sv
module rdptr_chk #(
  parameter int DEPTH    = 245760,
  parameter int PTR_W    = 18,
  parameter int WPB      = 40,
  parameter int BLK_BITS = 13
) (
  input logic                clk,
  input logic                rst_n,
  input logic                re,
  input logic [PTR_W-1:0]    ptr,
  input logic                busy,
  input logic                err,
  input logic                out_en,
  input logic                start,
  input logic                abort,
  input logic                load,
  input logic                bad,
  input logic [BLK_BITS-1:0] blk
);
  // R2
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start && !abort && re) |=>
      (32'(ptr) == (($past(32'(ptr)) == DEPTH - 1) ? 0 : $past(32'(ptr)) + 1)));

  // R2
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ptr) < DEPTH);

  // R3
  start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (ptr == '0 && !err));

  // R6
  load_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (32'(ptr) == 32'($past(blk)) * WPB && busy && !out_en));

  // R7
  bad_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> (err && !busy && $stable(ptr)));

  // R9
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (err && !busy && $stable(ptr)));

  // R9
  event_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start, abort, load, bad}));
endmodule

bind rdptr_ctrl rdptr_chk #(
  .DEPTH(DEPTH), .PTR_W(PTR_W), .WPB(WPB), .BLK_BITS(BLK_BITS)
) i_chk (
  .clk(clk), .rst_n(rst_n), .re(re), .ptr(ptr), .busy(busy), .err(err),
  .out_en(out_en), .start(rd_start), .abort(rd_abort), .load(seq_load),
  .bad(seq_bad), .blk(seq_blk)
);

// File: tb/test_rdptr_ctrl.sv
`timescale 1ns/1ps
module test_rdptr_ctrl;
  localparam int NB = 12, WPB = 4, BB = 4, LAT = 6;
  localparam int DEPTH = NB * WPB;
  localparam int PW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0, rd_rst = 1'b0, oe = 1'b0, re = 1'b0;
  logic [PW-1:0] ptr;
  logic out_en, busy, err;
  int vectors = 0, fails = 0, exp = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rdptr_ctrl #(.BLOCKS(NB), .WPB(WPB), .BLK_BITS(BB), .LATENCY(LAT)) i_rdptr_ctrl (
    .clk(clk), .rst_n(rst_n), .rd_rst(rd_rst), .oe(oe), .re(re),
    .ptr(ptr), .out_en(out_en), .busy(busy), .err(err)
  );

  task automatic chk(input string tag, input int act, input int expv);
    vectors++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic step(input logic r, input logic o, input logic e);
    @(negedge clk);
    rd_rst = r; oe = o; re = e;
    @(posedge clk);
    #1;
  endtask

  // two quiet active edges so the next strobe rise is honoured (R10)
  task automatic prelude();
    for (int i = 0; i < 2; i++) begin
      step(0, 0, 1);
      exp = (exp + 1) % DEPTH;
    end
  endtask

  task automatic unlock();
    prelude();
    step(1, 0, 1); exp = 0;
    chk("R3 ptr", int'(ptr), 0); chk("R3 err", int'(err), 0);
    chk("R12 busy", int'(busy), 1);
    step(0, 0, 1); exp = 1;
    step(0, 1, 0); step(0, 1, 0);
    chk("R5 out_en", int'(out_en), 0); chk("R12 busy", int'(busy), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ptr", int'(ptr), 0); chk("R1 out_en", int'(out_en), 0);
    chk("R1 busy", int'(busy), 0); chk("R1 err", int'(err), 0);
    rst_n = 1'b1;
    #1;
    chk("R1 ptr", int'(ptr), 0);

    // R2 / R11: stepping, holding, wrapping
    for (int i = 0; i < DEPTH + 20; i++) begin
      logic e, o;
      e = (i % 3 != 2);
      o = (i % 2 == 1);
      step(0, o, e);
      if (e) exp = (exp + 1) % DEPTH;
      chk("R2 ptr", int'(ptr), exp);
      chk("R11 out_en", int'(out_en), int'(o));
    end

    // R4: break the pattern on each of the four edges
    for (int k = 1; k <= 4; k++) begin
      prelude();
      for (int p = 1; p <= k; p++) begin
        logic o, e;
        if (p < k) begin o = (p > 2); e = (p <= 2); end
        else begin o = 1; e = 1; end
        step(p == 1, o, e);
        if (p == 1) exp = 0;
        else if (e) exp = (exp + 1) % DEPTH;
        if (p < k) chk("R12 busy", int'(busy), 1);
      end
      chk("R4 busy", int'(busy), 0);
      chk("R4 ptr", int'(ptr), exp);
      step(0, 1, 0);
      chk("R4 out_en", int'(out_en), 1);
    end

    // R5-R8: every block number, valid and invalid
    for (int b = 0; b < (1 << BB); b++) begin
      unlock();
      for (int i = BB - 1; i >= 0; i--) begin
        step(0, b[i], 0);
        if (i > 0 || b < NB) chk("R5 out_en", int'(out_en), 0);
      end
      if (b < NB) begin
        exp = b * WPB;
        chk("R6 ptr", int'(ptr), exp); chk("R6 busy", int'(busy), 1);
        for (int j = 1; j <= LAT; j++) begin
          step(0, (j % 2 == 1) && (j < LAT), 0);
          chk("R8 ptr", int'(ptr), exp);
          chk("R8 busy", int'(busy), int'(j < LAT));
          if (j < LAT) chk("R5 out_en", int'(out_en), 0);
        end
        step(0, 1, 1);
        exp = (exp + 1) % DEPTH;
        chk("R8 ptr", int'(ptr), exp); chk("R11 out_en", int'(out_en), 1);
      end else begin
        chk("R7 err", int'(err), 1); chk("R7 busy", int'(busy), 0);
        chk("R7 ptr", int'(ptr), 1);
      end
    end

    // R10: early strobe ignored
    prelude();
    step(1, 1, 1); exp = 0;
    chk("R3 ptr", int'(ptr), 0); chk("R4 busy", int'(busy), 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0);
    step(0, 0, 1); exp = 1;
    step(1, 0, 1); exp = 2;
    chk("R10 ptr", int'(ptr), 2); chk("R10 busy", int'(busy), 0);
    step(0, 0, 1); exp = 3;
    step(1, 0, 1); exp = 0;
    chk("R10 accepted ptr", int'(ptr), 0); chk("R10 busy", int'(busy), 1);
    // R9: second rise on edge 3
    step(0, 0, 1); exp = 1;
    step(1, 1, 0);
    chk("R9 err", int'(err), 1); chk("R9 busy", int'(busy), 0);
    chk("R9 ptr", int'(ptr), 1);

    // R9: second rise on the last address edge wins over the load (block 5)
    unlock();
    for (int i = BB - 1; i >= 0; i--) step(i == 0, 5 >> i, 0);
    chk("R9 err", int'(err), 1); chk("R9 busy", int'(busy), 0);
    chk("R9 ptr", int'(ptr), 1);

    // R9: second rise during the hold-off
    unlock();
    for (int i = BB - 1; i >= 0; i--) step(0, 3 >> i, 0);
    exp = 3 * WPB;
    chk("R6 ptr", int'(ptr), exp);
    step(0, 0, 0); step(0, 0, 0);
    step(1, 0, 0);
    chk("R9 err", int'(err), 1); chk("R9 busy", int'(busy), 0);
    chk("R9 ptr", int'(ptr), exp);
    step(0, 1, 1); exp = exp + 1;
    chk("R2 ptr", int'(ptr), exp);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule